// File: doc/BRIEF.md
# Serial Receive Character Buffer

This block sits between a serial deserializer and a host register interface. It stores incoming 8-bit characters until the host reads them. Each character arrives with a one-cycle strobe. A mode input selects one of two storage arrangements. In the first, a single holding slot keeps only the newest character. In the second, a first-in first-out queue keeps characters in arrival order.

The host sees three things: the character at the head of storage, placed in the low byte of a 32-bit word; a data-ready flag; and a sticky overrun flag. A read pulse consumes the head character. A clear pulse, issued when the host reads line status, resets the overrun flag.

The two modes handle excess input in opposite ways. In holding mode the newest character replaces the one that has not been read. In queue mode, once the queue is full, the stored characters are kept and the newcomer is lost. Both cases raise overrun. A change of mode empties storage.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, data-ready and overrun both read 0.
- R2: A character accepted on a strobe makes data-ready 1 from the next cycle. Data-ready stays 1 while any unread character is held and returns to 0 the cycle after the last one is read.
- R3: In holding mode (mode input 0), a character that arrives while one is unread replaces it, and overrun becomes 1.
- R4: In queue mode (mode input 1), the read word shows the oldest unread character, and each read pulse removes exactly that one character.
- R5: In queue mode with DEPTH characters held, an arriving character is discarded, the held characters and their order stay unchanged, and overrun becomes 1.
- R6: If a read pulse and a strobe fall in the same cycle while storage is full, the read is applied first: the new character is stored and overrun is not raised. This holds in both modes.
- R7: Overrun stays 1 until a clear pulse. If a new overrun event and a clear pulse occur in the same cycle, overrun stays 1.
- R8: Bits 31:8 of the read word are always 0.
- R9: In a cycle where the mode input differs from its value in the previous cycle, storage is emptied and any strobe in that cycle is ignored without raising overrun. Data-ready reads 0 in the next cycle.
- R10: A read pulse while data-ready is 0 has no effect on the flags or on later characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1 = queue mode, 0 = single holding slot |
| rx_valid_i | input | 1 | Strobe: a received character is present |
| rx_data_i | input | 8 | Received character |
| rd_i | input | 1 | Host read of the data word; consumes the head |
| ovr_clr_i | input | 1 | Host status read; clears overrun |
| rd_data_o | output | 32 | Head character, zero-extended |
| data_ready_o | output | 1 | Unread character present |
| overrun_o | output | 1 | Sticky overrun error |

## Verification
The bench builds the block with DEPTH set to 4 rather than the default of 16. With that depth, a full queue, a dropped character and pointer wraparound all occur within a handful of strobes. This lets the same run cover the full-queue overrun and read-before-write behaviour several times, around both wrap points of the circular storage. Holding mode needs no parameter and is covered in the same run before and after mode switches.

// File: rtl/uart_rxb_pkg.sv
`timescale 1ns/1ps
package uart_rxb_pkg;
  localparam int unsigned RXB_DW   = 8;
  localparam int unsigned RXB_BUSW = 32;
  typedef logic [RXB_DW-1:0] rxb_byte_t;
endpackage

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
// Circular character storage with push, pop, head overwrite and flush.
module rxb_store
  import uart_rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic                         ovw_i,
  input  rxb_byte_t                    wdata_i,
  output rxb_byte_t                    head_o,
  output logic [$clog2(DEPTH+1)-1:0]   occ_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  rxb_byte_t         mem [DEPTH];
  logic [PW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [PW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [CW-1:0]     occ_q, occ_d;
  logic [DEPTH-1:0]  wr_en;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // Per-entry write enables: a push targets the tail, an overwrite the head.
  for (genvar g = 0; g < DEPTH; g++) begin : g_wen
    assign wr_en[g] = (push_i && !flush_i && (wr_ptr_q == PW'(g))) ||
                      (ovw_i  && !flush_i && (rd_ptr_q == PW'(g)));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en[i]) mem[i] <= wdata_i;
    end
  end

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    occ_d    = occ_q;
    if (flush_i) begin
      rd_ptr_d = '0;
      wr_ptr_d = '0;
      occ_d    = '0;
    end else begin
      if (pop_i)  rd_ptr_d = ptr_inc(rd_ptr_q);
      if (push_i) wr_ptr_d = ptr_inc(wr_ptr_q);
      occ_d = occ_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      occ_q    <= occ_d;
    end
  end

  assign head_o = mem[rd_ptr_q];
  assign occ_o  = occ_q;
endmodule

// File: rtl/rxb_ovr.sv
`timescale 1ns/1ps
// Sticky error flag; a set in the same cycle as a clear wins.
module rxb_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/uart_rx_buf.sv
`timescale 1ns/1ps
module uart_rx_buf
  import uart_rxb_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fifo_en_i,
  input  logic                rx_valid_i,
  input  logic [RXB_DW-1:0]   rx_data_i,
  input  logic                rd_i,
  input  logic                ovr_clr_i,
  output logic [RXB_BUSW-1:0] rd_data_o,
  output logic                data_ready_o,
  output logic                overrun_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          mode_q;
  logic          mode_chg;
  logic [CW-1:0] occ;
  logic          full;
  logic          do_pop, do_push, do_ovw, ovr_set;
  rxb_byte_t     head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_en_i;
  end

  always_comb begin
    mode_chg = (fifo_en_i != mode_q);
    full     = fifo_en_i ? (occ == CW'(DEPTH)) : (occ != '0);
    // Read is applied before the incoming character.
    do_pop   = rd_i && (occ != '0) && !mode_chg;
    do_push  = rx_valid_i && !mode_chg && (!full || do_pop);
    ovr_set  = rx_valid_i && !mode_chg && full && !do_pop;
    do_ovw   = ovr_set && !fifo_en_i;
  end

  rxb_store #(.DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush_i (mode_chg),
    .push_i  (do_push),
    .pop_i   (do_pop),
    .ovw_i   (do_ovw),
    .wdata_i (rx_data_i),
    .head_o  (head),
    .occ_o   (occ)
  );

  rxb_ovr u_ovr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ovr_set),
    .clr_i  (ovr_clr_i),
    .flag_o (overrun_o)
  );

  assign rd_data_o    = {{(RXB_BUSW-RXB_DW){1'b0}}, head};
  assign data_ready_o = (occ != '0);
endmodule

// File: rtl/uart_rx_buf_chk.sv
`timescale 1ns/1ps
module uart_rx_buf_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        fifo_en_i,
  input logic                        rx_valid_i,
  input logic [7:0]                  rx_data_i,
  input logic                        rd_i,
  input logic                        ovr_clr_i,
  input logic [31:0]                 rd_data_o,
  input logic                        data_ready_o,
  input logic                        overrun_o,
  input logic                        mode_q,
  input logic [$clog2(DEPTH+1)-1:0]  occ
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // R2: an accepted strobe leaves unread data behind.
  a_r2_ready_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_i && fifo_en_i == mode_q && !rd_i) |=> data_ready_o);

  // R3: holding-mode replacement of an unread character.
  a_r3_hold_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en_i && !mode_q && data_ready_o && rx_valid_i && !rd_i)
      |=> (overrun_o && data_ready_o && rd_data_o[7:0] == $past(rx_data_i)));

  // R5: full queue keeps its head and raises overrun.
  a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_i && mode_q && occ == CW'(DEPTH) && rx_valid_i && !rd_i)
      |=> (overrun_o && $stable(rd_data_o)));

  // R7: sticky until cleared.
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  // R7: a clear with no strobe drops the flag.
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr_i && !rx_valid_i) |=> !overrun_o);

  // R8: upper bits of the read word are zero.
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[31:8] == 24'h0);

  // R9: a mode change empties storage.
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_i != mode_q) |=> !data_ready_o);

  // R10: a read with nothing held changes nothing.
  a_r10_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready_o && rd_i && !rx_valid_i) |=> !data_ready_o);
endmodule

bind uart_rx_buf uart_rx_buf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en_i    (fifo_en_i),
  .rx_valid_i   (rx_valid_i),
  .rx_data_i    (rx_data_i),
  .rd_i         (rd_i),
  .ovr_clr_i    (ovr_clr_i),
  .rd_data_o    (rd_data_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .mode_q       (mode_q),
  .occ          (occ)
);

// File: tb/uart_rx_buf_bench.sv
`timescale 1ns/1ps
module uart_rx_buf_bench;
  localparam int DEPTH = 4;

  logic        clk;
  logic        rst_n;
  logic        fifo_en;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rd;
  logic        ovr_clr;
  logic [31:0] rd_data;
  logic        data_ready;
  logic        overrun;

  int          checks;
  int          fails;
  logic [7:0]  exp_q[$];
  logic        exp_ovr;
  logic        mode_m;

  uart_rx_buf #(.DEPTH(DEPTH)) u_uart_rx_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_en_i    (fifo_en),
    .rx_valid_i   (rx_valid),
    .rx_data_i    (rx_data),
    .rd_i         (rd),
    .ovr_clr_i    (ovr_clr),
    .rd_data_o    (rd_data),
    .data_ready_o (data_ready),
    .overrun_o    (overrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor side: compare the ports against the scoreboard state.
  task automatic check_all(input string tag);
    chk(tag, {31'b0, data_ready}, {31'b0, exp_q.size() != 0});
    chk(tag, {31'b0, overrun}, {31'b0, exp_ovr});
    if (exp_q.size() != 0) chk(tag, rd_data, {24'b0, exp_q[0]});
    else                   chk("R8", {rd_data[31:8], 8'h0}, 32'h0);
  endtask

  // Driver side: one cycle of stimulus; the scoreboard is updated from the
  // requirements; a read compares the word the host saw against the queue head.
  task automatic step(input string tag, input logic v, input logic [7:0] d,
                      input logic r, input logic c);
    logic [31:0] seen;
    logic        setv;
    int          cap;
    rx_valid = v; rx_data = d; rd = r; ovr_clr = c;
    #1 seen = rd_data;
    @(posedge clk);
    if (r && exp_q.size() != 0) begin
      chk(tag, seen, {24'b0, exp_q[0]});
      void'(exp_q.pop_front());
    end
    setv = 1'b0;
    cap  = mode_m ? DEPTH : 1;
    if (v) begin
      if (exp_q.size() < cap) exp_q.push_back(d);
      else begin
        setv = 1'b1;
        if (!mode_m) exp_q[0] = d;
      end
    end
    exp_ovr = setv | (exp_ovr & ~c);
    @(negedge clk);
    rx_valid = 1'b0; rd = 1'b0; ovr_clr = 1'b0;
  endtask

  // Switch mode with a strobe in the same cycle (R9: it is ignored).
  task automatic set_mode(input logic m);
    fifo_en = m; rx_valid = 1'b1; rx_data = 8'hEE;
    @(posedge clk);
    exp_q.delete();
    mode_m = m;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; exp_ovr = 1'b0; mode_m = 1'b0;
    rst_n = 1'b0; fifo_en = 1'b0; rx_valid = 1'b0; rx_data = 8'h0;
    rd = 1'b0; ovr_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // Holding mode
    step("R2", 1, 8'h41, 0, 0); check_all("R2");
    step("R2", 0, 8'h00, 1, 0); check_all("R2");
    step("R10", 0, 8'h00, 1, 0); check_all("R10");
    step("R3", 1, 8'h42, 0, 0); check_all("R3");
    step("R3", 1, 8'h43, 0, 0); check_all("R3");
    step("R7", 0, 8'h00, 0, 0); check_all("R7");
    step("R7", 0, 8'h00, 0, 1); check_all("R7");
    step("R6", 1, 8'h44, 1, 0); check_all("R6");
    step("R8", 0, 8'h00, 0, 0); chk("R8", {rd_data[31:8], 8'h0}, 32'h0);

    // Mode change with data held
    set_mode(1'b1); check_all("R9");

    // Queue order, several bytes
    for (int i = 0; i < 3; i++) begin
      step("R4", 1, 8'h10 + 8'(i), 0, 0); check_all("R4");
    end
    for (int i = 0; i < 3; i++) begin
      step("R4", 0, 8'h00, 1, 0); check_all("R4");
    end

    // Fill, overflow, drain (crosses the wrap point)
    for (int i = 0; i < DEPTH; i++) begin
      step("R5", 1, 8'h20 + 8'(i), 0, 0);
    end
    check_all("R5");
    step("R5", 1, 8'h99, 0, 0); check_all("R5");
    step("R7", 1, 8'h98, 0, 1); check_all("R7");
    for (int i = 0; i < DEPTH; i++) begin
      step("R5", 0, 8'h00, 1, 0); check_all("R5");
    end
    step("R10", 0, 8'h00, 1, 1); check_all("R10");

    // Full queue: read and strobe in the same cycle
    for (int i = 0; i < DEPTH; i++) begin
      step("R6", 1, 8'h30 + 8'(i), 0, 0);
    end
    step("R6", 1, 8'h3F, 1, 0); check_all("R6");
    for (int i = 0; i < DEPTH; i++) begin
      step("R6", 0, 8'h00, 1, 0); check_all("R6");
    end

    // Back to holding mode with data present
    step("R9", 1, 8'h55, 0, 0);
    set_mode(1'b0); check_all("R9");
    step("R9", 1, 8'h66, 0, 0); check_all("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule